// File: doc/BRIEF.md
# Packet Mailbox Channel Controller

This block is the management-controller side of a packet channel between a host and a management controller. Packets move through a shared memory window. A one-byte mailbox carries interrupts in each direction. The block writes the window's control descriptor after reset and announces itself through the mailbox status register. It then negotiates a protocol version and a receive packet size when the host asks to initialise.

Once the channel is up, the block tracks who owns each packet buffer. An outgoing packet is announced with a Tx Begin byte, and the buffer comes back when the host returns Rx Complete. An incoming packet arrives as a Tx Begin from the host. It is handed back with Rx Complete once the local consumer reports it is done.

Every status register change is followed by a dummy data byte, because a status write alone may not interrupt the host. The payload copy and the host bus are handled elsewhere. The block sees only received command bytes, the output-buffer-full flag, and one-word writes into the window.

Top module: `pkt_chan_ctrl`

## Requirements
- R1: While reset is held, all strobes are low and the outputs are zero: out_cmd_we, stat_we, win_we, stat_val, tx_busy and rx_owned.
- R2: After reset, the block writes six 32-bit big-endian words into the window, with the first-listed field of a packed pair in bits 31:16. Only after these writes does it write the status value 0x80 (bit 7 = management side active). The words are:
  - word 0 = 0x4D435450
  - word 1 = {version minimum, version current}
  - word 4 = receive offset
  - word 5 = receive size
  - word 6 = transmit offset
  - word 7 = transmit size
- R3: After every status write, the next byte placed in the output data register is the dummy value 0xFF.
- R4: An output byte is written only when obf was low at the clock edge that issued it. Two output bytes are never written on consecutive cycles.
- R5: An Initialise command (0x00) received while the channel is inactive negotiates as follows:
  - The version is the lower of the two current versions.
  - The negotiation succeeds only if that version is at least both minima.
  - The size is the host's proposed receive size, clamped to the range [MIN_PKT, BUF_SZ].
  - On success, the block writes word 3 = {version, 16'h0000}, then words 5 and 7 = the size, then the status value 0xC0 (bit 6 = channel active).
- R6: A failed negotiation makes no window write and no status write. The channel stays inactive.
- R7: Once the channel is active, a further Initialise causes no window write and no status write.
- R8: Before the channel is active, received command bytes other than Initialise are ignored. A local transmit request is also ignored.
- R9: A host Tx Begin (0x01) while the channel is active and the receive buffer is not owned sets rx_owned. A later rx_done clears rx_owned and queues one Rx Complete byte (0x02). An rx_done while nothing is owned has no effect.
- R10: A tx_req is accepted only while the channel is active and tx_busy is low. Acceptance sets tx_busy and queues one Tx Begin byte (0x01). A tx_req while busy is ignored. A host Rx Complete (0x02) clears tx_busy.
- R11: When several output bytes are pending, they leave in this order: the dummy first, then Rx Complete, then Tx Begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_cmd_valid | input | 1 | Strobe: a host command byte was read from the input data register |
| rx_cmd | input | 8 | Host command byte |
| host_ver_min | input | 16 | Host minimum version field as seen in the window |
| host_ver_cur | input | 16 | Host current version field as seen in the window |
| host_rx_size | input | 32 | Receive size proposed by the host |
| tx_req | input | 1 | Local request to announce an outgoing packet |
| rx_done | input | 1 | Local consumer has finished with the incoming packet |
| obf | input | 1 | Output buffer full flag of the mailbox |
| out_cmd | output | 8 | Byte for the output data register |
| out_cmd_we | output | 1 | Write strobe for out_cmd |
| stat_we | output | 1 | Write strobe for the status register |
| stat_val | output | 8 | Status register value (bit 7 active, bit 6 channel active) |
| win_we | output | 1 | Window word write strobe |
| win_addr | output | WIN_AW | Window word index |
| win_data | output | 32 | Big-endian window word |
| tx_busy | output | 1 | An outgoing packet awaits Rx Complete |
| rx_owned | output | 1 | The incoming buffer belongs to this side |

## Verification
The bench holds the output-buffer-full flag high while a status update, an Rx Complete and a Tx Begin all become pending. A design with the wrong priority, or with no OBF gate, would emit the bytes out of order or overwrite an unread byte. The bench also sends a failing negotiation, a repeated Initialise and early commands before the channel is up. A design that did not ignore these would rewrite the frozen control area or take buffer ownership too soon. A size proposal below the minimum checks the clamp. A seeded random mix of requests and host commands checks that no Tx Begin or Rx Complete is lost or duplicated.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam logic [7:0] CMD_INIT  = 8'h00;
  localparam logic [7:0] CMD_TXB   = 8'h01;
  localparam logic [7:0] CMD_RXC   = 8'h02;
  localparam logic [7:0] CMD_DUMMY = 8'hFF;

  localparam logic [31:0] WIN_MAGIC = 32'h4D43_5450;

  // word indices inside the control descriptor
  localparam int W_MAGIC = 0;
  localparam int W_BVER  = 1;
  localparam int W_NEG   = 3;
  localparam int W_RXOFF = 4;
  localparam int W_RXSZ  = 5;
  localparam int W_TXOFF = 6;
  localparam int W_TXSZ  = 7;

  localparam logic [7:0] ST_ACTIVE = 8'h80;
  localparam logic [7:0] ST_CHAN   = 8'hC0;

  typedef enum logic [2:0] {
    SQ_BOOT, SQ_ACT, SQ_IDLE, SQ_NVER, SQ_NRX, SQ_NTX, SQ_CHAN, SQ_UP
  } seq_t;
endpackage

// File: rtl/pcc_negotiate.sv
module pcc_negotiate #(
  parameter logic [15:0] VER_MIN = 16'd1,
  parameter logic [15:0] VER_CUR = 16'd2,
  parameter logic [31:0] MIN_PKT = 32'd68,
  parameter logic [31:0] BUF_SZ  = 32'd256
) (
  input  logic [15:0] host_min,
  input  logic [15:0] host_cur,
  input  logic [31:0] host_sz,
  output logic        ok,
  output logic [15:0] ver,
  output logic [31:0] sz
);
  always_comb begin
    ver = (VER_CUR < host_cur) ? VER_CUR : host_cur;
    ok  = (ver >= VER_MIN) && (ver >= host_min);
    if (host_sz < MIN_PKT)     sz = MIN_PKT;
    else if (host_sz > BUF_SZ) sz = BUF_SZ;
    else                       sz = host_sz;
  end
endmodule

// File: rtl/pcc_seq.sv
module pcc_seq
  import pcc_pkg::*;
#(
  parameter int          WIN_AW  = 3,
  parameter logic [15:0] VER_MIN = 16'd1,
  parameter logic [15:0] VER_CUR = 16'd2,
  parameter logic [31:0] RX_OFF  = 32'h100,
  parameter logic [31:0] TX_OFF  = 32'h200,
  parameter logic [31:0] BUF_SZ  = 32'd256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_cmd,
  input  logic              neg_ok,
  input  logic [15:0]       neg_ver_in,
  input  logic [31:0]       neg_sz_in,
  output logic              win_we,
  output logic [WIN_AW-1:0] win_addr,
  output logic [31:0]       win_data,
  output logic              stat_we,
  output logic [7:0]        stat_val,
  output logic              dummy_req
);
  localparam int BOOT_N = 6;
  localparam int STEP_W = $clog2(BOOT_N);

  seq_t              st;
  logic [STEP_W-1:0] step;
  logic [15:0]       neg_ver;
  logic [31:0]       neg_sz;
  logic [WIN_AW-1:0] boot_addr;
  logic [31:0]       boot_data;

  always_comb begin
    case (step)
      STEP_W'(0): begin boot_addr = WIN_AW'(W_MAGIC); boot_data = WIN_MAGIC;          end
      STEP_W'(1): begin boot_addr = WIN_AW'(W_BVER);  boot_data = {VER_MIN, VER_CUR}; end
      STEP_W'(2): begin boot_addr = WIN_AW'(W_RXOFF); boot_data = RX_OFF;             end
      STEP_W'(3): begin boot_addr = WIN_AW'(W_RXSZ);  boot_data = BUF_SZ;             end
      STEP_W'(4): begin boot_addr = WIN_AW'(W_TXOFF); boot_data = TX_OFF;             end
      default:    begin boot_addr = WIN_AW'(W_TXSZ);  boot_data = BUF_SZ;             end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_BOOT;
      step      <= '0;
      win_we    <= 1'b0;
      win_addr  <= '0;
      win_data  <= '0;
      stat_we   <= 1'b0;
      stat_val  <= '0;
      dummy_req <= 1'b0;
      neg_ver   <= '0;
      neg_sz    <= '0;
    end else begin
      win_we    <= 1'b0;
      stat_we   <= 1'b0;
      dummy_req <= 1'b0;
      case (st)
        SQ_BOOT: begin
          win_we   <= 1'b1;
          win_addr <= boot_addr;
          win_data <= boot_data;
          if (step == STEP_W'(BOOT_N - 1)) st <= SQ_ACT;
          else step <= step + 1'b1;
        end
        SQ_ACT: begin
          stat_we   <= 1'b1;
          stat_val  <= ST_ACTIVE;
          dummy_req <= 1'b1;
          st        <= SQ_IDLE;
        end
        SQ_IDLE: if (init_cmd && neg_ok) begin
          neg_ver <= neg_ver_in;
          neg_sz  <= neg_sz_in;
          st      <= SQ_NVER;
        end
        SQ_NVER: begin
          win_we   <= 1'b1;
          win_addr <= WIN_AW'(W_NEG);
          win_data <= {neg_ver, 16'h0000};
          st       <= SQ_NRX;
        end
        SQ_NRX: begin
          win_we   <= 1'b1;
          win_addr <= WIN_AW'(W_RXSZ);
          win_data <= neg_sz;
          st       <= SQ_NTX;
        end
        SQ_NTX: begin
          win_we   <= 1'b1;
          win_addr <= WIN_AW'(W_TXSZ);
          win_data <= neg_sz;
          st       <= SQ_CHAN;
        end
        SQ_CHAN: begin
          stat_we   <= 1'b1;
          stat_val  <= ST_CHAN;
          dummy_req <= 1'b1;
          st        <= SQ_UP;
        end
        default: st <= SQ_UP;
      endcase
    end
  end
endmodule

// File: rtl/pcc_own.sv
module pcc_own (
  input  logic clk,
  input  logic rst,
  input  logic chan_up,
  input  logic host_txb,
  input  logic host_rxc,
  input  logic tx_req,
  input  logic rx_done,
  output logic tx_busy,
  output logic rx_owned,
  output logic req_txb,
  output logic req_rxc
);
  logic rx_take;

  always_comb begin
    req_txb = chan_up && tx_req && !tx_busy;
    req_rxc = rx_owned && rx_done;
    rx_take = chan_up && host_txb && !rx_owned;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_busy  <= 1'b0;
      rx_owned <= 1'b0;
    end else begin
      if (req_txb)                  tx_busy <= 1'b1;
      else if (chan_up && host_rxc) tx_busy <= 1'b0;
      if (rx_take)      rx_owned <= 1'b1;
      else if (req_rxc) rx_owned <= 1'b0;
    end
  end
endmodule

// File: rtl/pcc_out_arb.sv
module pcc_out_arb
  import pcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_dummy,
  input  logic       req_rxc,
  input  logic       req_txb,
  input  logic       obf,
  output logic [7:0] out_cmd,
  output logic       out_we
);
  logic pd, pr, pt;
  logic can, g_d, g_r, g_t;

  always_comb begin
    can = !obf && !out_we;
    g_d = can && pd;
    g_r = can && pr && !pd;
    g_t = can && pt && !pd && !pr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pd      <= 1'b0;
      pr      <= 1'b0;
      pt      <= 1'b0;
      out_we  <= 1'b0;
      out_cmd <= '0;
    end else begin
      pd     <= (pd && !g_d) || req_dummy;
      pr     <= (pr && !g_r) || req_rxc;
      pt     <= (pt && !g_t) || req_txb;
      out_we <= g_d || g_r || g_t;
      if (g_d)      out_cmd <= CMD_DUMMY;
      else if (g_r) out_cmd <= CMD_RXC;
      else if (g_t) out_cmd <= CMD_TXB;
    end
  end
endmodule

// File: rtl/pkt_chan_ctrl.sv
module pkt_chan_ctrl
  import pcc_pkg::*;
#(
  parameter int          WIN_AW  = 3,
  parameter logic [15:0] VER_MIN = 16'd1,
  parameter logic [15:0] VER_CUR = 16'd2,
  parameter logic [31:0] RX_OFF  = 32'h100,
  parameter logic [31:0] TX_OFF  = 32'h200,
  parameter logic [31:0] BUF_SZ  = 32'd256,
  parameter logic [31:0] MIN_PKT = 32'd68
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_cmd_valid,
  input  logic [7:0]        rx_cmd,
  input  logic [15:0]       host_ver_min,
  input  logic [15:0]       host_ver_cur,
  input  logic [31:0]       host_rx_size,
  input  logic              tx_req,
  input  logic              rx_done,
  input  logic              obf,
  output logic [7:0]        out_cmd,
  output logic              out_cmd_we,
  output logic              stat_we,
  output logic [7:0]        stat_val,
  output logic              win_we,
  output logic [WIN_AW-1:0] win_addr,
  output logic [31:0]       win_data,
  output logic              tx_busy,
  output logic              rx_owned
);
  logic        neg_ok, dummy_req, req_txb, req_rxc;
  logic [15:0] neg_ver;
  logic [31:0] neg_sz;
  logic        is_init, is_txb, is_rxc, chan_up;

  always_comb begin
    is_init = rx_cmd_valid && (rx_cmd == CMD_INIT);
    is_txb  = rx_cmd_valid && (rx_cmd == CMD_TXB);
    is_rxc  = rx_cmd_valid && (rx_cmd == CMD_RXC);
    chan_up = stat_val[6];
  end

  pcc_negotiate #(.VER_MIN(VER_MIN), .VER_CUR(VER_CUR), .MIN_PKT(MIN_PKT), .BUF_SZ(BUF_SZ))
  u_neg (.host_min(host_ver_min), .host_cur(host_ver_cur), .host_sz(host_rx_size),
         .ok(neg_ok), .ver(neg_ver), .sz(neg_sz));

  pcc_seq #(.WIN_AW(WIN_AW), .VER_MIN(VER_MIN), .VER_CUR(VER_CUR),
            .RX_OFF(RX_OFF), .TX_OFF(TX_OFF), .BUF_SZ(BUF_SZ))
  u_seq (.clk(clk), .rst(rst), .init_cmd(is_init), .neg_ok(neg_ok),
         .neg_ver_in(neg_ver), .neg_sz_in(neg_sz),
         .win_we(win_we), .win_addr(win_addr), .win_data(win_data),
         .stat_we(stat_we), .stat_val(stat_val), .dummy_req(dummy_req));

  pcc_own u_own (.clk(clk), .rst(rst), .chan_up(chan_up), .host_txb(is_txb),
                 .host_rxc(is_rxc), .tx_req(tx_req), .rx_done(rx_done),
                 .tx_busy(tx_busy), .rx_owned(rx_owned),
                 .req_txb(req_txb), .req_rxc(req_rxc));

  pcc_out_arb u_arb (.clk(clk), .rst(rst), .req_dummy(dummy_req), .req_rxc(req_rxc),
                     .req_txb(req_txb), .obf(obf), .out_cmd(out_cmd), .out_we(out_cmd_we));
endmodule

// File: rtl/pcc_chk.sv
module pcc_chk (
  input logic       clk,
  input logic       rst,
  input logic       obf,
  input logic       out_cmd_we,
  input logic [7:0] out_cmd,
  input logic       stat_we,
  input logic [7:0] stat_val,
  input logic       win_we
);
  logic dummy_due;

  always_ff @(posedge clk) begin
    if (rst) dummy_due <= 1'b0;
    else if (stat_we) dummy_due <= 1'b1;
    else if (out_cmd_we) dummy_due <= 1'b0;
  end

  // R3
  dummy_after_stat_chk: assert property (@(posedge clk) disable iff (rst)
    (out_cmd_we && dummy_due) |-> (out_cmd == 8'hFF));

  // R4
  obf_gate_chk: assert property (@(posedge clk) disable iff (rst)
    out_cmd_we |-> !$past(obf));

  // R4
  no_back2back_chk: assert property (@(posedge clk) disable iff (rst)
    out_cmd_we |=> !out_cmd_we);

  // R7
  ctrl_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    stat_val[6] |-> !win_we);

  // R10
  txb_needs_chan_chk: assert property (@(posedge clk) disable iff (rst)
    (out_cmd_we && out_cmd == 8'h01) |-> stat_val[6]);
endmodule

bind pkt_chan_ctrl pcc_chk i_pcc_chk (
  .clk(clk), .rst(rst), .obf(obf), .out_cmd_we(out_cmd_we), .out_cmd(out_cmd),
  .stat_we(stat_we), .stat_val(stat_val), .win_we(win_we)
);

// File: tb/test_pkt_chan_ctrl.sv
module test_pkt_chan_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_cmd_valid = 1'b0;
  logic [7:0]  rx_cmd = '0;
  logic [15:0] host_ver_min = '0, host_ver_cur = '0;
  logic [31:0] host_rx_size = '0;
  logic        tx_req = 1'b0, rx_done = 1'b0;
  logic        obf;
  logic [7:0]  out_cmd;
  logic        out_cmd_we, stat_we, win_we, tx_busy, rx_owned;
  logic [7:0]  stat_val;
  logic [2:0]  win_addr;
  logic [31:0] win_data;

  pkt_chan_ctrl i_pkt_chan_ctrl (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic obf_r = 0, hold = 0, auto_rd = 1;
  int age = 0;
  logic [31:0] win_m [8];
  int wr_cnt = 0, st_cnt = 0, out_n = 0, n01 = 0, n02 = 0;
  logic [7:0] out_log [1024];

  assign obf = obf_r | hold;

  // monitor and mailbox model, sampled away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      obf_r = 0;
    end else begin
      if (win_we) begin win_m[win_addr] = win_data; wr_cnt++; end
      if (stat_we) st_cnt++;
      if (out_cmd_we) begin
        out_log[out_n % 1024] = out_cmd;
        out_n++;
        if (out_cmd == 8'h01) n01++;
        if (out_cmd == 8'h02) n02++;
        obf_r = 1; age = 0;
      end else if (obf_r && auto_rd) begin
        age++;
        if (age >= 2) obf_r = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic host_cmd(input logic [7:0] b);
    @(negedge clk); rx_cmd_valid = 1; rx_cmd = b;
    @(negedge clk); rx_cmd_valid = 0;
  endtask

  task automatic pulse_tx();
    @(negedge clk); tx_req = 1; @(negedge clk); tx_req = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); rx_done = 1; @(negedge clk); rx_done = 0;
  endtask

  task automatic wait_out(input int n);
    for (int i = 0; i < 200 && out_n < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int s, b01, b02, st0;
    bit m_busy, m_own;
    int e01, e02;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!out_cmd_we && !stat_we && !win_we, "R1", "strobes", {out_cmd_we, stat_we, win_we}, 0);
    chk(stat_val == 0 && !tx_busy && !rx_owned, "R1", "state", {stat_val, tx_busy, rx_owned}, 0);
    rst = 0;

    // R2 boot descriptor
    for (int i = 0; i < 50 && !stat_val[7]; i++) @(negedge clk);
    chk(stat_val == 8'h80, "R2", "active status", stat_val, 8'h80);
    chk(wr_cnt == 6, "R2", "boot writes before status", wr_cnt, 6);
    chk(win_m[0] == 32'h4D435450, "R2", "magic", win_m[0], 32'h4D435450);
    chk(win_m[1] == {16'd1, 16'd2}, "R2", "versions", win_m[1], {16'd1, 16'd2});
    chk(win_m[4] == 32'h100 && win_m[6] == 32'h200, "R2", "offsets", {win_m[4][15:0], win_m[6][15:0]}, 32'h0100_0200);
    chk(win_m[5] == 32'd256 && win_m[7] == 32'd256, "R2", "sizes", win_m[5], 256);
    wait_out(1);
    chk(out_n == 1 && out_log[0] == 8'hFF, "R3", "dummy after active", out_log[0], 8'hFF);

    // R8 commands before channel active
    host_cmd(8'h01);
    repeat (3) @(negedge clk);
    chk(!rx_owned, "R8", "early Tx Begin ignored", rx_owned, 0);
    pulse_tx();
    repeat (10) @(negedge clk);
    chk(!tx_busy && out_n == 1, "R8", "early tx_req ignored", out_n, 1);

    // R6 failing negotiation: host min 4, cur 5 -> version 2 < 4
    host_ver_min = 16'd4; host_ver_cur = 16'd5; host_rx_size = 32'd20;
    host_cmd(8'h00);
    repeat (20) @(negedge clk);
    chk(wr_cnt == 6 && st_cnt == 1, "R6", "no writes on failure", wr_cnt, 6);
    chk(stat_val == 8'h80, "R6", "channel stays inactive", stat_val, 8'h80);

    // R5 successful negotiation with OBF held, R11 ordering
    host_ver_min = 16'd1; host_ver_cur = 16'd3;
    hold = 1;
    host_cmd(8'h00);
    for (int i = 0; i < 50 && !stat_val[6]; i++) @(negedge clk);
    chk(stat_val == 8'hC0, "R5", "channel status", stat_val, 8'hC0);
    chk(win_m[3] == {16'd2, 16'd0}, "R5", "negotiated version", win_m[3], {16'd2, 16'd0});
    chk(win_m[5] == 32'd68 && win_m[7] == 32'd68, "R5", "clamped size", win_m[5], 68);
    chk(wr_cnt == 9, "R5", "write count", wr_cnt, 9);
    host_cmd(8'h01);
    @(negedge clk);
    chk(rx_owned, "R9", "Tx Begin takes buffer", rx_owned, 1);
    pulse_done();
    chk(!rx_owned, "R9", "rx_done releases", rx_owned, 0);
    pulse_tx();
    chk(tx_busy, "R10", "tx accepted", tx_busy, 1);
    s = out_n;
    repeat (10) @(negedge clk);
    chk(out_n == s, "R4", "no byte while obf high", out_n, s);
    hold = 0;
    wait_out(s + 3);
    chk(out_log[s] == 8'hFF, "R11", "first dummy", out_log[s], 8'hFF);
    chk(out_log[s + 1] == 8'h02, "R11", "second Rx Complete", out_log[s + 1], 8'h02);
    chk(out_log[s + 2] == 8'h01, "R11", "third Tx Begin", out_log[s + 2], 8'h01);

    // R7 repeated Initialise
    host_ver_cur = 16'd1;
    host_cmd(8'h00);
    repeat (20) @(negedge clk);
    chk(wr_cnt == 9 && st_cnt == 2, "R7", "frozen control area", wr_cnt, 9);

    // R10 busy rejection and release, R9 spurious rx_done
    b01 = n01; b02 = n02;
    pulse_tx();
    pulse_done();
    repeat (10) @(negedge clk);
    chk(n01 == b01, "R10", "tx_req while busy ignored", n01, b01);
    chk(n02 == b02, "R9", "rx_done without ownership ignored", n02, b02);
    host_cmd(8'h02);
    chk(!tx_busy, "R10", "Rx Complete clears busy", tx_busy, 0);
    pulse_tx();
    wait_out(out_n + 1);
    repeat (5) @(negedge clk);
    chk(n01 == b01 + 1 && tx_busy, "R10", "new Tx Begin", n01, b01 + 1);
    host_cmd(8'h02);

    // random mix against a bench model
    m_busy = 0; m_own = 0; e01 = 0; e02 = 0;
    b01 = n01; b02 = n02; st0 = st_cnt;
    for (int it = 0; it < 400; it++) begin
      case ($urandom % 4)
        0: begin pulse_tx(); if (!m_busy) begin m_busy = 1; e01++; end end
        1: begin pulse_done(); if (m_own) begin m_own = 0; e02++; end end
        2: begin host_cmd(8'h01); m_own = 1; end
        default: begin host_cmd(8'h02); m_busy = 0; end
      endcase
      repeat ($urandom % 4) @(negedge clk);
      if (it % 40 == 0)
        chk(tx_busy == m_busy && rx_owned == m_own, "R10", "random ownership",
            {tx_busy, rx_owned}, {m_busy, m_own});
    end
    repeat (60) @(negedge clk);
    chk(n01 - b01 == e01, "R10", "random Tx Begin count", n01 - b01, e01);
    chk(n02 - b02 == e02, "R9", "random Rx Complete count", n02 - b02, e02);
    chk(tx_busy == m_busy && rx_owned == m_own, "R9", "final ownership",
        {tx_busy, rx_owned}, {m_busy, m_own});
    chk(st_cnt == st0, "R7", "no status change in traffic", st_cnt, st0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule